// File: doc/BRIEF.md
# Mode-Dependent Memory Address Pointer

This block keeps the 11-bit byte address of a 2048-byte serial memory. The upper three bits come from the block-select field of the device-select byte. The lower eight bits come from the word-address byte. The bus decoder strobes each field into the pointer as that field's acknowledge is issued. After each data byte the decoder pulses an advance strobe, and the pointer moves to the next byte. How it moves depends on the transfer direction. In a write, the pointer stays inside the current 32-byte page. In a read, it runs through the whole array.

The pointer keeps its value between transfers. A read that sends no word address therefore continues from the byte after the last one accessed. The block drives the current address, and the 6-bit page index used by a page write buffer. All pins are plain control and data pins with no handshake. A strobe takes effect at the clock edge where it is high, and the new address appears on the outputs after that edge.

Top module: `addr_pointer`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, the address output is 0.
- R2: When `ld_blk_i` is high at an edge, address bits 10..8 take `blk_i`, and bits 7..0 keep their value.
- R3: When `ld_word_i` is high at an edge, address bits 7..0 take `word_i`, and bits 10..8 keep their value.
- R4: When `step_i` is high and `rd_mode_i` is 0 (write), bits 4..0 increment modulo 32 and bits 10..5 are unchanged. For example, 31 goes to 0 and 63 goes to 32.
- R5: When `step_i` is high and `rd_mode_i` is 1 (read), all 11 bits increment modulo 2048, so 2047 goes to 0.
- R6: When any load strobe is high in the same cycle as `step_i`, the loads are applied and the step is discarded.
- R7: When no strobe is high, the address holds its value whatever `rd_mode_i`, `blk_i` and `word_i` do.
- R8: `page_o` always equals address bits 10..5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ld_blk_i | input | 1 | Load block-select bits |
| blk_i | input | 3 | Block-select value |
| ld_word_i | input | 1 | Load word-address byte |
| word_i | input | 8 | Word-address value |
| step_i | input | 1 | Advance after a data byte |
| rd_mode_i | input | 1 | 1 = read (linear wrap), 0 = write (page wrap) |
| addr_o | output | 11 | Current address |
| page_o | output | 6 | Current page index |

## Verification
Two functions can meet in one cycle: a field load and an advance. The bench provokes this directly by raising `step_i` together with `ld_blk_i`, with `ld_word_i`, or with both. It also does so in sequences drawn from a pseudo-random stream. In each case the address must show the loaded fields with no increment applied. A behavioural model gives the expected value, and the bench compares against it on every clock.

// File: rtl/addr_pointer_pkg.sv
package addr_pointer_pkg;
  parameter int unsigned BLK_W  = 3;
  parameter int unsigned WORD_W = 8;
  parameter int unsigned OFS_W  = 5;
  localparam int unsigned ADDR_W = BLK_W + WORD_W;
  localparam int unsigned PAGE_W = ADDR_W - OFS_W;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef enum logic {MODE_WR = 1'b0, MODE_RD = 1'b1} mode_e;
endpackage

// File: rtl/addr_loader.sv
module addr_loader
  import addr_pointer_pkg::*;
(
  input  addr_t             cur_i,
  input  logic              ld_blk_i,
  input  logic [BLK_W-1:0]  blk_i,
  input  logic              ld_word_i,
  input  logic [WORD_W-1:0] word_i,
  output addr_t             nxt_o,
  output logic              any_ld_o
);
  always_comb begin
    nxt_o = cur_i;
    if (ld_blk_i)  nxt_o[ADDR_W-1:WORD_W] = blk_i;
    if (ld_word_i) nxt_o[WORD_W-1:0]      = word_i;
    any_ld_o = ld_blk_i | ld_word_i;
  end
endmodule

// File: rtl/addr_stepper.sv
module addr_stepper
  import addr_pointer_pkg::*;
(
  input  addr_t cur_i,
  input  mode_e mode_i,
  output addr_t nxt_o
);
  addr_t lin;
  logic [OFS_W-1:0] ofs;
  always_comb begin
    lin = cur_i + addr_t'(1);
    ofs = cur_i[OFS_W-1:0] + OFS_W'(1);
    if (mode_i == MODE_RD) nxt_o = lin;
    else                   nxt_o = {cur_i[ADDR_W-1:OFS_W], ofs};
  end
endmodule

// File: rtl/addr_pointer.sv
module addr_pointer
  import addr_pointer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_blk_i,
  input  logic [2:0]        blk_i,
  input  logic              ld_word_i,
  input  logic [7:0]        word_i,
  input  logic              step_i,
  input  logic              rd_mode_i,
  output logic [10:0]       addr_o,
  output logic [5:0]        page_o
);
  addr_t ptr_q, ld_nxt, st_nxt;
  logic  any_ld;

  addr_loader u_load (
    .cur_i(ptr_q), .ld_blk_i(ld_blk_i), .blk_i(blk_i),
    .ld_word_i(ld_word_i), .word_i(word_i),
    .nxt_o(ld_nxt), .any_ld_o(any_ld)
  );

  addr_stepper u_step (
    .cur_i(ptr_q), .mode_i(mode_e'(rd_mode_i)), .nxt_o(st_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (any_ld) ptr_q <= ld_nxt;
    else if (step_i) ptr_q <= st_nxt;
  end

  assign addr_o = ptr_q;
  assign page_o = ptr_q[ADDR_W-1:OFS_W];
endmodule

// File: rtl/addr_pointer_chk.sv
module addr_pointer_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ld_blk_i,
  input logic [2:0]  blk_i,
  input logic        ld_word_i,
  input logic [7:0]  word_i,
  input logic        step_i,
  input logic        rd_mode_i,
  input logic [10:0] addr_o,
  input logic [5:0]  page_o
);
  AST_BLK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_blk_i |=> addr_o[10:8] == $past(blk_i)); // R2
  AST_WORD_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_word_i |=> addr_o[7:0] == $past(word_i)); // R3
  AST_WR_PAGE_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !rd_mode_i && !ld_blk_i && !ld_word_i) |=>
      (addr_o[10:5] == $past(addr_o[10:5]) &&
       addr_o[4:0] == 5'($past(addr_o[4:0]) + 5'd1))); // R4
  AST_RD_LINEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && rd_mode_i && !ld_blk_i && !ld_word_i) |=>
      addr_o == 11'($past(addr_o) + 11'd1)); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !ld_blk_i && !ld_word_i) |=> $stable(addr_o)); // R7
  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && ld_blk_i && ld_word_i) |=> addr_o == {$past(blk_i), $past(word_i)}); // R6
  always_comb if (rst_ni) AST_PAGE_MATCH: assert (page_o == addr_o[10:5]); // R8
endmodule

bind addr_pointer addr_pointer_chk u_chk (.*);

// File: tb/addr_pointer_bench.sv
module addr_pointer_bench;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0;
  logic ld_blk = 0, ld_word = 0, step = 0, rd_mode = 0;
  logic [2:0] blk = 0;
  logic [7:0] word = 0;
  logic [10:0] addr;
  logic [5:0] page;
  int checks = 0, errors = 0;
  int model = 0;
  int cyc = 0;
  bit done = 0;

  addr_pointer u_addr_pointer (
    .clk_i(clk), .rst_ni(rst_n), .ld_blk_i(ld_blk), .blk_i(blk),
    .ld_word_i(ld_word), .word_i(word), .step_i(step), .rd_mode_i(rd_mode),
    .addr_o(addr), .page_o(page));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural model: updated at each edge from the inputs seen there
  always @(posedge clk) begin
    if (rst_n) begin
      if (ld_blk || ld_word) begin
        if (ld_blk)  model = (blk * 256) + (model % 256);
        if (ld_word) model = (model / 256) * 256 + word;
      end else if (step) begin
        if (rd_mode) model = (model + 1) % 2048;
        else model = (model / 32) * 32 + ((model % 32) + 1) % 32;
      end
    end
  end

  // compare every clock at the falling edge
  always @(negedge clk) if (rst_n && !done) begin
    chk("R1-R7 model", addr, model);
    chk("R8 page", page, addr / 32);
  end

  task automatic drive(input bit lb, input int b, input bit lw, input int w,
                       input bit st, input bit rd);
    @(negedge clk);
    ld_blk = lb; blk = 3'(b); ld_word = lw; word = 8'(w); step = st; rd_mode = rd;
    @(negedge clk);
    ld_blk = 0; ld_word = 0; step = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", addr, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", addr, 0);
    drive(1, 5, 0, 0, 0, 0); chk("R2 block load", addr, 5*256);
    drive(0, 0, 1, 8'h3E, 0, 0); chk("R3 word load", addr, 5*256 + 8'h3E);
    drive(0, 0, 0, 0, 1, 0); chk("R4 step", addr, 5*256 + 8'h3F);
    drive(0, 0, 0, 0, 1, 0); chk("R4 page wrap 63->32", addr, 5*256 + 8'h20);
    drive(1, 0, 1, 31, 0, 0); drive(0, 0, 0, 0, 1, 0);
    chk("R4 wrap 31->0", addr, 0);
    drive(1, 7, 1, 255, 0, 1); drive(0, 0, 0, 0, 1, 1);
    chk("R5 wrap 2047->0", addr, 0);
    drive(1, 2, 1, 8'hFF, 0, 1); drive(0, 0, 0, 0, 1, 1);
    chk("R5 block carry", addr, 3*256);
    drive(1, 6, 0, 0, 1, 1); chk("R6 blk+step", addr, 6*256);
    drive(0, 0, 1, 9, 1, 0); chk("R6 word+step", addr, 6*256 + 9);
    drive(1, 1, 1, 77, 1, 1); chk("R6 both+step", addr, 256 + 77);
    @(negedge clk); blk = 3'd4; word = 8'd200; rd_mode = 1;
    @(negedge clk); rd_mode = 0;
    @(negedge clk); chk("R7 hold", addr, 256 + 77);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      ld_blk = ($urandom % 8) == 0; ld_word = ($urandom % 8) == 0;
      step = $urandom % 2; rd_mode = $urandom % 2;
      blk = 3'($urandom); word = 8'($urandom);
    end
    @(negedge clk); ld_blk = 0; ld_word = 0; step = 0;
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule